// File: doc/BRIEF.md
# Burst Geometry Monitor

A passive observer for one memory-mapped address channel and the data channel that belongs to it. When an address handshake completes, the monitor latches the request's start address, length field, size field and burst type. It decodes these into a beat count, a per-beat byte count and a total byte count, and presents them on its outputs. In the same step it flags any combination the protocol forbids. These are: a beat wider than the data bus, the reserved burst type, a wrapping burst with an unsupported length or a misaligned start, a fixed burst longer than sixteen beats, and a length that does not fit the configured field width.

While the burst is open, the monitor counts data handshakes. It checks that the last-beat marker arrives together with the final expected beat and not before. The burst closes on the final beat or on an early marker. All error flags stay set until a synchronous clear is pulsed. An informational output reports a start address that is not a multiple of the beat width; it is not an error. Only one burst is tracked at a time, and the block drives nothing back onto the bus.

Top module: `burst_geom_mon`

## Requirements
- R1: Geometry is captured only in a cycle where `a_valid` and `a_ready` are both high. In every other cycle the geometry outputs and `burst_open` keep their values.
- R2: `g_beats` is the length field plus one. In the 8-bit length mode, a length of 0 gives 1 beat and a length of 255 gives 256 beats.
- R3: `g_bytes_per_beat` equals 2 raised to the 3-bit size field (1 to 128). `g_total_bytes` equals `g_beats` times `g_bytes_per_beat`.
- R4: `err_size` is set when the beat width exceeds `BUS_BYTES`. A beat width equal to or narrower than the bus raises no error.
- R5: The burst type is encoded as 0 fixed, 1 incrementing, 2 wrapping and 3 reserved. Capturing type 3 sets `err_burst`.
- R6: For a wrapping burst, a beat count other than 2, 4, 8 or 16 sets `err_wrap_len`. When the count is legal, a start address that is not a multiple of `g_total_bytes` sets `err_wrap_align`.
- R7: A fixed burst with more than 16 beats sets `err_fixed_len`. Incrementing bursts of 1 to 256 beats set no length error.
- R8: With `AXI4 = 0`, only the low 4 bits of the length field count, so bursts are 1 to 16 beats. Any nonzero bit among length bits 7..4 sets `err_len_width`.
- R9: A data beat counts only while a burst is open and `d_valid` and `d_ready` are both high. The burst closes on the final expected beat. A final beat that carries `d_last` closes it with no error, and beats that arrive while no burst is open are ignored.
- R10: `d_last` on a counted beat before the final expected one sets `err_last_early` and closes the burst.
- R11: A final expected beat without `d_last` sets `err_last_missing` and closes the burst.
- R12: An address handshake while a burst is open sets `err_overlap`. It leaves the open burst and its geometry unchanged.
- R13: `unaligned` is high while the captured start address is not a multiple of the beat width. It does not set any error flag.
- R14: Error flags are sticky until `clr_err` is pulsed, and a new error event takes priority over a clear in the same cycle. Synchronous active-low `rst_n` zeroes all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_err | input | 1 | Clears all sticky error flags |
| a_valid | input | 1 | Address channel valid |
| a_ready | input | 1 | Address channel ready |
| a_addr | input | ADDR_W | Start address of the burst |
| a_len | input | 8 | Length field (beats minus one) |
| a_size | input | 3 | Size field (log2 of bytes per beat) |
| a_burst | input | 2 | Burst type |
| d_valid | input | 1 | Data channel valid |
| d_ready | input | 1 | Data channel ready |
| d_last | input | 1 | Last-beat marker |
| g_beats | output | 9 | Captured beat count |
| g_bytes_per_beat | output | 8 | Captured bytes per beat |
| g_total_bytes | output | 16 | Captured total byte count |
| burst_open | output | 1 | A burst is being tracked |
| unaligned | output | 1 | Start address not a multiple of beat width |
| err_size | output | 1 | Beat wider than bus |
| err_burst | output | 1 | Reserved burst type |
| err_wrap_len | output | 1 | Illegal wrapping length |
| err_wrap_align | output | 1 | Wrapping start not aligned to burst size |
| err_fixed_len | output | 1 | Fixed burst over 16 beats |
| err_len_width | output | 1 | Length exceeds the 4-bit field |
| err_last_early | output | 1 | Last marker before final beat |
| err_last_missing | output | 1 | Final beat without last marker |
| err_overlap | output | 1 | Address handshake while a burst is open |

## Verification
The bench builds two copies that watch the same stimulus. One uses the 8-bit length mode on an 8-byte bus, so 256-beat bursts and 16-byte-plus sizes are within reach. The other uses the 4-bit length mode on a 4-byte bus, so the length-width error, low-nibble truncation and size errors at 8 bytes all show up. Because the two copies decode the same bursts into different beat counts, a single data stream drives them through different outcomes: one closes cleanly while the other sees an early or missing last marker, or stays open.

// File: rtl/burst_geom_mon.sv
module burst_geom_mon #(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8,
  parameter bit AXI4      = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_err,
  input  logic              a_valid,
  input  logic              a_ready,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [7:0]        a_len,
  input  logic [2:0]        a_size,
  input  logic [1:0]        a_burst,
  input  logic              d_valid,
  input  logic              d_ready,
  input  logic              d_last,
  output logic [8:0]        g_beats,
  output logic [7:0]        g_bytes_per_beat,
  output logic [15:0]       g_total_bytes,
  output logic              burst_open,
  output logic              unaligned,
  output logic              err_size,
  output logic              err_burst,
  output logic              err_wrap_len,
  output logic              err_wrap_align,
  output logic              err_fixed_len,
  output logic              err_len_width,
  output logic              err_last_early,
  output logic              err_last_missing,
  output logic              err_overlap
);

  localparam logic [1:0] BT_FIXED = 2'd0;
  localparam logic [1:0] BT_WRAP  = 2'd2;
  localparam logic [1:0] BT_RSVD  = 2'd3;
  localparam logic [8:0] BUS_LIM  = 9'(BUS_BYTES);

  logic [8:0]  cnt;
  logic [7:0]  len_used;
  logic [8:0]  beats_n;
  logic [7:0]  bpb_n;
  logic [15:0] total_n;

  wire a_hs  = a_valid & a_ready;
  wire take  = a_hs & ~burst_open;
  wire d_take = d_valid & d_ready & burst_open;

  assign len_used = AXI4 ? a_len : {4'b0000, a_len[3:0]};
  assign beats_n  = {1'b0, len_used} + 9'd1;
  assign bpb_n    = 8'd1 << a_size;
  assign total_n  = 16'(beats_n) << a_size;

  wire wrap_cnt_ok = (beats_n == 9'd2) | (beats_n == 9'd4) |
                     (beats_n == 9'd8) | (beats_n == 9'd16);
  wire is_wrap   = (a_burst == BT_WRAP);
  wire bad_size  = {1'b0, bpb_n} > BUS_LIM;
  wire bad_type  = (a_burst == BT_RSVD);
  wire bad_wlen  = is_wrap & ~wrap_cnt_ok;
  wire bad_walign = is_wrap & wrap_cnt_ok &
                    (|(a_addr & ADDR_W'(total_n - 16'd1)));
  wire bad_fixed = (a_burst == BT_FIXED) & (beats_n > 9'd16);
  wire bad_lenw  = ~AXI4 & (|a_len[7:4]);
  wire misal     = |(a_addr & ADDR_W'(bpb_n - 8'd1));

  wire [8:0] cnt_nx = cnt + 9'd1;
  wire at_end      = (cnt_nx == g_beats);
  wire ev_early    = d_take & d_last & ~at_end;
  wire ev_missing  = d_take & at_end & ~d_last;
  wire closing     = d_take & (d_last | at_end);
  wire ev_overlap  = a_hs & burst_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_beats          <= '0;
      g_bytes_per_beat <= '0;
      g_total_bytes    <= '0;
      burst_open       <= 1'b0;
      unaligned        <= 1'b0;
      cnt              <= '0;
    end else if (take) begin
      g_beats          <= beats_n;
      g_bytes_per_beat <= bpb_n;
      g_total_bytes    <= total_n;
      unaligned        <= misal;
      burst_open       <= 1'b1;
      cnt              <= '0;
    end else if (closing) begin
      burst_open       <= 1'b0;
      cnt              <= '0;
    end else if (d_take) begin
      cnt              <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_size         <= 1'b0;
      err_burst        <= 1'b0;
      err_wrap_len     <= 1'b0;
      err_wrap_align   <= 1'b0;
      err_fixed_len    <= 1'b0;
      err_len_width    <= 1'b0;
      err_last_early   <= 1'b0;
      err_last_missing <= 1'b0;
      err_overlap      <= 1'b0;
    end else begin
      err_size         <= (err_size         & ~clr_err) | (take & bad_size);
      err_burst        <= (err_burst        & ~clr_err) | (take & bad_type);
      err_wrap_len     <= (err_wrap_len     & ~clr_err) | (take & bad_wlen);
      err_wrap_align   <= (err_wrap_align   & ~clr_err) | (take & bad_walign);
      err_fixed_len    <= (err_fixed_len    & ~clr_err) | (take & bad_fixed);
      err_len_width    <= (err_len_width    & ~clr_err) | (take & bad_lenw);
      err_last_early   <= (err_last_early   & ~clr_err) | ev_early;
      err_last_missing <= (err_last_missing & ~clr_err) | ev_missing;
      err_overlap      <= (err_overlap      & ~clr_err) | ev_overlap;
    end
  end

  p_geom_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    burst_open |=> ($stable(g_beats) && $stable(g_total_bytes)));

  p_open_on_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready && !burst_open) |=> burst_open);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_open && !(a_valid && a_ready)) |=> (!burst_open && $stable(g_beats)));

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_open |-> (cnt < g_beats));

  p_early_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_open && d_valid && d_ready && d_last) |=> !burst_open);

  p_overlap_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready && burst_open) |=> err_overlap);

  p_sticky_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (err_last_missing && !clr_err) |=> err_last_missing);

  p_size_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready && !burst_open) |=>
      (({1'b0, g_bytes_per_beat} <= BUS_LIM) || err_size));

endmodule

// File: tb/burst_geom_mon_bench.sv
module burst_geom_mon_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_err = 1'b0;
  logic a_valid = 1'b0, a_ready = 1'b0;
  logic [31:0] a_addr = '0;
  logic [7:0] a_len = '0;
  logic [2:0] a_size = '0;
  logic [1:0] a_burst = '0;
  logic d_valid = 1'b0, d_ready = 1'b0, d_last = 1'b0;

  logic [8:0]  ob [2];
  logic [7:0]  op [2];
  logic [15:0] ot [2];
  logic [8:0]  oe [2];
  logic        oo [2];
  logic        ou [2];

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_geom_mon #(.ADDR_W(32), .BUS_BYTES(8), .AXI4(1'b1)) u_burst_geom_mon (
    .clk(clk), .rst_n(rst_n), .clr_err(clr_err),
    .a_valid(a_valid), .a_ready(a_ready), .a_addr(a_addr), .a_len(a_len),
    .a_size(a_size), .a_burst(a_burst),
    .d_valid(d_valid), .d_ready(d_ready), .d_last(d_last),
    .g_beats(ob[0]), .g_bytes_per_beat(op[0]), .g_total_bytes(ot[0]),
    .burst_open(oo[0]), .unaligned(ou[0]),
    .err_size(oe[0][0]), .err_burst(oe[0][1]), .err_wrap_len(oe[0][2]),
    .err_wrap_align(oe[0][3]), .err_fixed_len(oe[0][4]), .err_len_width(oe[0][5]),
    .err_last_early(oe[0][6]), .err_last_missing(oe[0][7]), .err_overlap(oe[0][8])
  );

  burst_geom_mon #(.ADDR_W(32), .BUS_BYTES(4), .AXI4(1'b0)) u_burst_geom_mon_axi3 (
    .clk(clk), .rst_n(rst_n), .clr_err(clr_err),
    .a_valid(a_valid), .a_ready(a_ready), .a_addr(a_addr), .a_len(a_len),
    .a_size(a_size), .a_burst(a_burst),
    .d_valid(d_valid), .d_ready(d_ready), .d_last(d_last),
    .g_beats(ob[1]), .g_bytes_per_beat(op[1]), .g_total_bytes(ot[1]),
    .burst_open(oo[1]), .unaligned(ou[1]),
    .err_size(oe[1][0]), .err_burst(oe[1][1]), .err_wrap_len(oe[1][2]),
    .err_wrap_align(oe[1][3]), .err_fixed_len(oe[1][4]), .err_len_width(oe[1][5]),
    .err_last_early(oe[1][6]), .err_last_missing(oe[1][7]), .err_overlap(oe[1][8])
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int b);
    case (b)
      0: return "R4";
      1: return "R5";
      2, 3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R10";
      7: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic int beats_of(input int d, input logic [7:0] len);
    return (d == 0) ? int'(len) + 1 : int'(len[3:0]) + 1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    a_valid = 0; a_ready = 0; d_valid = 0; d_ready = 0; d_last = 0; clr_err = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_addr(input logic [31:0] ad, input logic [7:0] ln,
                         input logic [2:0] sz, input logic [1:0] bt);
    a_addr = ad; a_len = ln; a_size = sz; a_burst = bt;
    a_valid = 1'b1;
    a_ready = 1'b0;
    repeat ($urandom % 2) @(negedge clk);
    a_ready = 1'b1;
    @(negedge clk);
    a_valid = 1'b0; a_ready = 1'b0;
  endtask

  task automatic do_data(input int n, input int l);
    for (int i = 0; i < n; i++) begin
      if ($urandom % 3 == 0) begin
        d_valid = 1'b1; d_ready = 1'b0; d_last = 1'b1;
        @(negedge clk);
      end
      d_valid = 1'b1; d_ready = 1'b1; d_last = (i == l);
      @(negedge clk);
    end
    d_valid = 1'b0; d_ready = 1'b0; d_last = 1'b0;
  endtask

  task automatic check_dut(input int d, input logic [31:0] ad, input logic [7:0] ln,
                           input logic [2:0] sz, input logic [1:0] bt,
                           input int n, input int l);
    int e, bpb, tot, bb;
    bit open_e;
    logic [8:0] ex;
    e   = beats_of(d, ln);
    bpb = 1 << sz;
    tot = e * bpb;
    bb  = (d == 0) ? 8 : 4;
    ex  = '0;
    ex[0] = bpb > bb;
    ex[1] = (bt == 2'd3);
    ex[2] = (bt == 2'd2) && !(e == 2 || e == 4 || e == 8 || e == 16);
    ex[3] = (bt == 2'd2) && !ex[2] && ((ad % tot) != 0);
    ex[4] = (bt == 2'd0) && (e > 16);
    ex[5] = (d == 1) && (ln[7:4] != 4'd0);
    open_e = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (open_e) begin
        if (i == l && i + 1 < e) begin ex[6] = 1'b1; open_e = 1'b0; end
        else if (i + 1 == e) begin
          if (i != l) ex[7] = 1'b1;
          open_e = 1'b0;
        end
      end
    end
    chk((d == 0) ? "R2" : "R8", "beats", int'(ob[d]), e);
    chk("R3", "bytes_per_beat", int'(op[d]), bpb);
    chk("R3", "total_bytes", int'(ot[d]), tot);
    for (int b = 0; b < 9; b++)
      chk(tag_of(b), $sformatf("err_bit%0d", b), int'(oe[d][b]), int'(ex[b]));
    chk("R13", "unaligned", int'(ou[d]), int'((ad % bpb) != 0));
    chk("R9", "burst_open", int'(oo[d]), int'(open_e));
  endtask

  task automatic run_trial(input logic [31:0] ad, input logic [7:0] ln,
                           input logic [2:0] sz, input logic [1:0] bt,
                           input int n, input int l);
    do_reset();
    do_addr(ad, ln, sz, bt);
    do_data(n, l);
    check_dut(0, ad, ln, sz, bt, n, l);
    check_dut(1, ad, ln, sz, bt, n, l);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk("R14", "reset beats", int'(ob[d]), 0);
      chk("R14", "reset total", int'(ot[d]), 0);
      chk("R14", "reset errors", int'(oe[d]), 0);
      chk("R14", "reset open", int'(oo[d]), 0);
    end

    a_valid = 1'b1; a_ready = 1'b0; a_len = 8'd5; a_size = 3'd1; a_burst = 2'd1;
    repeat (3) @(negedge clk);
    a_valid = 1'b0; a_ready = 1'b1;
    repeat (2) @(negedge clk);
    a_ready = 1'b0;
    for (int d = 0; d < 2; d++) begin
      chk("R1", "beats held without handshake", int'(ob[d]), 0);
      chk("R1", "open held without handshake", int'(oo[d]), 0);
    end

    d_valid = 1'b1; d_ready = 1'b1; d_last = 1'b1;
    @(negedge clk);
    d_valid = 1'b0; d_ready = 1'b0; d_last = 1'b0;
    for (int d = 0; d < 2; d++) begin
      chk("R9", "stray beat early", int'(oe[d][6]), 0);
      chk("R9", "stray beat missing", int'(oe[d][7]), 0);
      chk("R9", "stray beat open", int'(oo[d]), 0);
    end

    run_trial(32'h100, 8'd3, 3'd2, 2'd1, 4, 3);
    run_trial(32'h0, 8'd255, 3'd3, 2'd1, 256, 255);
    run_trial(32'h0, 8'd0, 3'd0, 2'd1, 1, 0);
    run_trial(32'h108, 8'd3, 3'd2, 2'd2, 4, 3);
    run_trial(32'h110, 8'd3, 3'd2, 2'd2, 4, 3);
    run_trial(32'h0, 8'd2, 3'd2, 2'd2, 3, 2);
    run_trial(32'h0, 8'd16, 3'd2, 2'd0, 17, 16);
    run_trial(32'h0, 8'd15, 3'd2, 2'd0, 16, 15);
    run_trial(32'h3, 8'd7, 3'd2, 2'd1, 8, 2);
    run_trial(32'h4, 8'd7, 3'd3, 2'd1, 8, -1);
    run_trial(32'h0, 8'd1, 3'd7, 2'd3, 2, 1);

    do_reset();
    do_addr(32'h40, 8'd3, 3'd2, 2'd1);
    do_addr(32'h80, 8'd9, 3'd1, 2'd1);
    for (int d = 0; d < 2; d++) begin
      chk("R12", "overlap flag", int'(oe[d][8]), 1);
      chk("R12", "geometry kept", int'(ob[d]), 4);
    end
    do_data(4, 3);
    for (int d = 0; d < 2; d++) begin
      chk("R9", "closed after overlap", int'(oo[d]), 0);
      chk("R9", "no last error", int'(oe[d][7:6]), 0);
      chk("R14", "overlap sticky", int'(oe[d][8]), 1);
    end
    clr_err = 1'b1;
    @(negedge clk);
    clr_err = 1'b0;
    for (int d = 0; d < 2; d++)
      chk("R14", "flags cleared", int'(oe[d]), 0);

    for (int t = 0; t < 250; t++) begin
      logic [31:0] ad;
      logic [7:0]  ln;
      int e4, n, l, mode;
      ad = $urandom;
      if ($urandom % 2 == 0) ad[15:0] = 16'h0;
      ln = ($urandom % 4 == 0) ? 8'($urandom % 256) : 8'($urandom % 20);
      e4 = int'(ln) + 1;
      mode = $urandom % 3;
      if (mode == 0) begin n = e4; l = e4 - 1; end
      else if (mode == 1) begin n = 1 + ($urandom % e4); l = n - 1; end
      else begin n = e4; l = -1; end
      run_trial(ad, ln, 3'($urandom % 8), 2'($urandom % 4), n, l);
    end

    finish_run();
  end
endmodule